// File: doc/BRIEF.md
# Card Presence Debounce and Supply Hold-Off Supervisor

This block sits between the card-slot contacts, the supply monitor and the host. It combines two raw presence contacts of opposite polarity into one card-present indication. It filters that indication with a debounce counter and reports it on an active-low status line. It also keeps any card session from starting until a hold-off interval has elapsed after the supply becomes good.

The host opens a session by pulling its active-low command line low. The session stays open until the host releases the line. If the card is pulled out, or the supply fails, while a session is open, the block does three things. It emits a one-cycle deactivate request, it closes the session, and it holds the status line low until the host releases its command. When no session is open and no fault is latched, the status line simply follows the debounced presence: high means a card is present and low means the slot is empty.

Top module: `card_presence_supervisor`

## Requirements
- R1: The raw presence is true when `pres_low_n` is 0 or `pres_high` is 1, and false only when `pres_low_n` is 1 and `pres_high` is 0.
- R2: Each presence pin passes through two synchronizing flops. A raw presence value that differs from the accepted one is taken over after DEBOUNCE_CYCLES consecutive synchronized samples, so the accepted value changes on the (DEBOUNCE_CYCLES+2)th rising edge after the pins change.
- R3: A disagreement that lasts fewer than DEBOUNCE_CYCLES synchronized samples is discarded, and the count starts again from zero.
- R4: With no session open and no fault latched, `status_n` equals the accepted presence (1 when a card is present, 0 when none).
- R5: `holdoff_busy` is 1 out of reset and whenever `supply_ok` is 0. After `supply_ok` rises it clears on the HOLDOFF_CYCLES-th rising edge. While it is 1, `session_on` stays 0 and command edges are ignored.
- R6: A session opens on the edge after `cmd_n` goes from 1 to 0, provided that hold-off is over, `supply_ok` is 1 and a card is accepted as present. A command that is already low when hold-off ends opens nothing. While a session is open, `status_n` is 1.
- R7: If the accepted presence drops during a session, the session closes, `deact_req` is 1 for exactly one cycle, and `status_n` stays 0 until `cmd_n` returns to 1.
- R8: If `supply_ok` is 0 at a rising edge during a session, then on that same edge the session closes, `deact_req` pulses for one cycle, the fault is latched and hold-off restarts.
- R9: The host raising `cmd_n` closes a session without any `deact_req` pulse and clears a latched fault.
- R10: In reset, `status_n`, `session_on` and `deact_req` are 0 and `holdoff_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pres_low_n | input | 1 | Raw presence contact, active low |
| pres_high | input | 1 | Raw presence contact, active high |
| supply_ok | input | 1 | Supply-good flag, synchronous to clk |
| cmd_n | input | 1 | Host activation command, active low |
| status_n | output | 1 | Active-low status/interrupt to the host |
| deact_req | output | 1 | One-cycle card deactivation request |
| session_on | output | 1 | Session open |
| holdoff_busy | output | 1 | Power-up hold-off running |

## Verification
The debounce path is driven with random levels on both contacts, each level held for a random length from one cycle up to about twice the debounce count. A bench model of the synchronizer delay and the consecutive-sample rule predicts `status_n` every cycle. This mix distinguishes a correct restart-on-disagreement from a counter that merely pauses or accumulates across glitches. Directed sequences hold a change for exactly DEBOUNCE_CYCLES+1 and DEBOUNCE_CYCLES+2 edges, and drive each contact alone, which exposes off-by-one latency and polarity faults. Session sequences then open a session and end it three ways: card removal, supply loss and host release. They tell a single deactivate pulse from a missing or repeated one, and show whether the status line is held low until the host acknowledges.

// File: rtl/card_presence_supervisor.sv
module card_presence_supervisor #(
  parameter int DEBOUNCE_CYCLES = 80000,
  parameter int HOLDOFF_CYCLES  = 2200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pres_low_n,
  input  logic pres_high,
  input  logic supply_ok,
  input  logic cmd_n,
  output logic status_n,
  output logic deact_req,
  output logic session_on,
  output logic holdoff_busy
);

  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int HW = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [DW-1:0] DB_LAST = DW'(DEBOUNCE_CYCLES - 1);
  localparam logic [HW-1:0] HO_LAST = HW'(HOLDOFF_CYCLES - 1);

  logic [1:0]    low_sync, high_sync;
  logic          raw_now;
  logic          card_in;
  logic [DW-1:0] db_cnt;
  logic [HW-1:0] ho_cnt;
  logic          cmd_q;
  logic          fault_q;
  logic          lost;
  logic          start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_sync  <= 2'b11;
      high_sync <= 2'b00;
    end else begin
      low_sync  <= {low_sync[0], pres_low_n};
      high_sync <= {high_sync[0], pres_high};
    end
  end

  assign raw_now = ~low_sync[1] | high_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_in <= 1'b0;
      db_cnt  <= '0;
    end else if (raw_now != card_in) begin
      if (db_cnt == DB_LAST) begin
        card_in <= raw_now;
        db_cnt  <= '0;
      end else begin
        db_cnt <= db_cnt + 1'b1;
      end
    end else begin
      db_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdoff_busy <= 1'b1;
      ho_cnt       <= '0;
    end else if (!supply_ok) begin
      holdoff_busy <= 1'b1;
      ho_cnt       <= '0;
    end else if (holdoff_busy) begin
      if (ho_cnt == HO_LAST) holdoff_busy <= 1'b0;
      else                   ho_cnt <= ho_cnt + 1'b1;
    end
  end

  assign lost  = session_on & (~supply_ok | ~card_in);
  assign start = cmd_q & ~cmd_n & ~holdoff_busy & supply_ok & card_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= 1'b1;
      session_on <= 1'b0;
      deact_req  <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      cmd_q     <= cmd_n;
      deact_req <= lost;
      if (lost) begin
        session_on <= 1'b0;
        fault_q    <= 1'b1;
      end else if (cmd_n) begin
        session_on <= 1'b0;
        fault_q    <= 1'b0;
      end else if (start) begin
        session_on <= 1'b1;
      end
    end
  end

  assign status_n = rst_n & ~fault_q & (session_on | card_in);

  // R7
  deact_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> !deact_req);

  // R8
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (session_on && !supply_ok) |=> (deact_req && !session_on && holdoff_busy));

  // R5
  holdoff_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    session_on |-> !holdoff_busy);

  // R7
  deact_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> !status_n);

  // R6
  open_needs_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(session_on) |-> $past(card_in && !cmd_n));

endmodule

// File: tb/tb_card_presence_supervisor.sv
`timescale 1ns/1ps
module tb_card_presence_supervisor;
  localparam int DEB  = 16;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pres_low_n = 1'b1, pres_high = 1'b0, supply_ok = 1'b1, cmd_n = 1'b1;
  logic status_n, deact_req, session_on, holdoff_busy;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  card_presence_supervisor #(.DEBOUNCE_CYCLES(DEB), .HOLDOFF_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .pres_low_n(pres_low_n), .pres_high(pres_high),
    .supply_ok(supply_ok), .cmd_n(cmd_n), .status_n(status_n),
    .deact_req(deact_req), .session_on(session_on), .holdoff_busy(holdoff_busy));

  always #2.5 clk = ~clk;

  function automatic logic exp_raw(input logic ln, input logic h);
    return ~ln | h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_card(input logic ln, input logic h);
    pres_low_n = ln; pres_high = h;
    step(DEB + 4);
  endtask

  logic m_s1 = 0, m_s2 = 0, m_acc = 0;
  int m_cnt = 0;

  initial begin
    int pulses;
    logic use_s2;
    void'($urandom(32'h5eed_1234));
    step(3);
    chk("R10 status_n", status_n, 0);
    chk("R10 session_on", session_on, 0);
    chk("R10 deact_req", deact_req, 0);
    chk("R10 holdoff_busy", holdoff_busy, 1);
    rst_n = 1'b1;

    // R2 R3 R4 R1: random contact levels against a model
    for (int seg = 0; seg < 200; seg++) begin
      int len = $urandom_range(1, 2 * DEB);
      logic ln = 1'($urandom_range(0, 1));
      logic h  = 1'($urandom_range(0, 1));
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        chk("R2/R3/R4 status_n vs debounce model", status_n, m_acc);
        pres_low_n = ln; pres_high = h;
        use_s2 = m_s2; m_s2 = m_s1; m_s1 = exp_raw(ln, h);
        if (use_s2 != m_acc) begin
          if (m_cnt == DEB - 1) begin m_acc = use_s2; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end
    end

    // R1: each contact alone
    set_card(1'b1, 1'b0); chk("R1 none active", status_n, 0);
    set_card(1'b0, 1'b0); chk("R1 low contact only", status_n, 1);
    set_card(1'b1, 1'b0); chk("R1 none again", status_n, 0);
    set_card(1'b1, 1'b1); chk("R1 high contact only", status_n, 1);
    set_card(1'b1, 1'b0);

    // R2 exact latency
    pres_high = 1'b1;
    step(DEB + 1); chk("R2 not yet accepted", status_n, 0);
    step(1);       chk("R2 accepted", status_n, 1);
    // R3 glitch of DEB-1 then DEB-1 again (restart)
    pres_high = 1'b0; step(DEB - 1); pres_high = 1'b1; step(3);
    pres_high = 1'b0; step(DEB - 1); pres_high = 1'b1; step(DEB + 4);
    chk("R3 short absences discarded", status_n, 1);

    // R5 hold-off timing and command ignored
    supply_ok = 1'b0; step(3);
    chk("R5 busy with supply low", holdoff_busy, 1);
    supply_ok = 1'b1;
    step(5); cmd_n = 1'b0; step(2); cmd_n = 1'b1;
    chk("R5 command ignored during hold-off", session_on, 0);
    step(HOLD - 10); cmd_n = 1'b0; step(2);
    chk("R5 busy before last edge", holdoff_busy, 1);
    step(1);
    chk("R5 busy cleared", holdoff_busy, 0);
    step(3);
    chk("R6 held-low command opens nothing", session_on, 0);
    cmd_n = 1'b1; step(2);

    // R6 open
    cmd_n = 1'b0; step(1);
    chk("R6 session open", session_on, 1);
    chk("R6 status high in session", status_n, 1);

    // R7 card removal
    pres_high = 1'b0; pulses = 0;
    step(DEB + 2);
    chk("R7 session still open before loss seen", session_on, 1);
    for (int i = 0; i < 6; i++) begin step(1); pulses += deact_req; end
    chk("R7 single deact pulse", pulses, 1);
    chk("R7 session closed", session_on, 0);
    chk("R7 status low", status_n, 0);
    set_card(1'b1, 1'b1);
    chk("R7 status held low until release", status_n, 0);
    cmd_n = 1'b1; step(1);
    chk("R9 release clears fault", status_n, 1);

    // R8 supply loss
    step(2); cmd_n = 1'b0; step(1);
    chk("R8 session open", session_on, 1);
    supply_ok = 1'b0; step(1);
    chk("R8 deact pulse", deact_req, 1);
    chk("R8 session closed", session_on, 0);
    chk("R8 hold-off restarted", holdoff_busy, 1);
    chk("R8 status low", status_n, 0);
    step(1);
    chk("R8 pulse ended", deact_req, 0);
    cmd_n = 1'b1; step(1);
    chk("R9 status follows card after release", status_n, 1);
    supply_ok = 1'b1; step(HOLD + 2);

    // R9 host release
    cmd_n = 1'b0; step(1);
    chk("R9 session open", session_on, 1);
    cmd_n = 1'b1; pulses = 0;
    for (int i = 0; i < 4; i++) begin step(1); pulses += deact_req; end
    chk("R9 session closed", session_on, 0);
    chk("R9 no deact pulse", pulses, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule